// File: doc/BRIEF.md
# Mixed-Width Synchronous FIFO with Programmable Almost Flags

This block is a single-clock first-in first-out buffer built over a 4,608-bit storage array. The write side and the read side each pick their own word width from a small set of aspect ratios (1, 2, 4, 9 or 18 bits). Data pushed at one width can be popped at another. A stream written four bits at a time, for example, can be drained one bit at a time, and pairs of 9-bit words can be read back as single 18-bit words.

The block keeps its write and read address counters internally. It tracks the amount of stored data with one-bit granularity. Four status flags are driven from that count: empty, full, almost-empty and almost-full. The two almost thresholds are ordinary inputs, so they can be changed while the FIFO runs. Both thresholds are expressed in read-port words.

Top module: `fifo_mw`

## Requirements
- R1: The mode inputs select a port width: code 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 9 bits, 4 = 18 bits; codes 5 to 7 act as 1 bit. Only the low width bits of `wr_data` are stored. Bits of `rd_data` above the read width read as zero. The modes change only while `rst` is high.
- R2: When the read port is narrower than the write port, each written word is returned least-significant slice first.
- R3: When the read port is wider than the write port, the first written word lands in the least-significant bits of the read word.
- R4: `full` is high when the free space, in bits, is less than one write word. A write while `full` is high is ignored and stores nothing.
- R5: `empty` is high when the stored data, in bits, is less than one read word. A read while `empty` is high is ignored and `rd_data` keeps its value.
- R6: Read data appears on `rd_data` in the cycle after the read is accepted. Otherwise `rd_data` holds.
- R7: A read and a write in the same cycle, with the FIFO neither empty nor full, both take effect.
- R8: `almost_full` is high when occupancy in bits is at or above `afull_lvl` times the read width. It follows the threshold value sampled at the previous clock edge.
- R9: `almost_empty` is high when occupancy in bits is at or below `aempty_lvl` times the read width.
- R10: A synchronous reset clears both pointers, the occupancy and `rd_data`. It sets `empty` and `almost_empty` and clears `full` and `almost_full`.
- R11: The capacity is the full array of 4,608 bits. In 18-bit mode exactly 256 words fit, and `full` and `empty` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 3 | Write port width code |
| rd_mode | input | 3 | Read port width code |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word, right-aligned |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Read word, right-aligned, registered |
| afull_lvl | input | 13 | Almost-full threshold in read words |
| aempty_lvl | input | 13 | Almost-empty threshold in read words |
| empty | output | 1 | Less than one read word stored |
| full | output | 1 | Less than one write word of room |
| almost_empty | output | 1 | Occupancy at or below the almost-empty threshold |
| almost_full | output | 1 | Occupancy at or above the almost-full threshold |

## Verification
The assertions assume that both mode codes stay constant between resets. Under that assumption each pointer stays aligned to its own port width, and the read and write regions of the array never overlap. Requests may arrive in any cycle, including while the FIFO is full or empty, and the thresholds may hold any value. The bench changes the modes only inside its reset task, with `rst` held high. It deliberately issues writes while full and reads while empty to exercise the rejection paths.

// File: rtl/fifo_mw_pkg.sv
package fifo_mw_pkg;

    localparam int ARRAY_BITS = 4608;
    localparam int PORT_W     = 18;
    localparam int MODE_W     = 3;
    localparam int WID_W      = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_X1  = 3'd0,
        MODE_X2  = 3'd1,
        MODE_X4  = 3'd2,
        MODE_X9  = 3'd3,
        MODE_X18 = 3'd4
    } port_mode_e;

    typedef struct packed {
        logic empty;
        logic full;
        logic aempty;
        logic afull;
    } fifo_flags_t;

    // Width in bits of a port in the given mode; unused codes act as 1 bit.
    function automatic logic [WID_W-1:0] mode_width(input logic [MODE_W-1:0] m);
        case (m)
            MODE_X2:  return 5'd2;
            MODE_X4:  return 5'd4;
            MODE_X9:  return 5'd9;
            MODE_X18: return 5'd18;
            default:  return 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/fifo_mw_ptr.sv
// Bit-address counter that advances by one port word and wraps at the array size.
module fifo_mw_ptr #(
    parameter int DEPTH = fifo_mw_pkg::ARRAY_BITS,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           adv,
    input  logic [fifo_mw_pkg::WID_W-1:0]  step,
    output logic [AW-1:0]                  ptr
);
    logic [AW:0] sum;

    always_comb begin
        sum = {1'b0, ptr} + (AW+1)'(step);
        if (sum >= (AW+1)'(DEPTH))
            sum = sum - (AW+1)'(DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (adv)
            ptr <= sum[AW-1:0];
    end
endmodule

// File: rtl/fifo_mw_store.sv
// Bit-addressed storage: writes and reads of variable width at any bit offset.
module fifo_mw_store #(
    parameter int DEPTH = fifo_mw_pkg::ARRAY_BITS,
    parameter int DW    = fifo_mw_pkg::PORT_W,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [AW-1:0]                  waddr,
    input  logic [fifo_mw_pkg::WID_W-1:0]  wwidth,
    input  logic [DW-1:0]                  wdata,
    input  logic                           re,
    input  logic [AW-1:0]                  raddr,
    input  logic [fifo_mw_pkg::WID_W-1:0]  rwidth,
    output logic [DW-1:0]                  rdata
);
    logic [DEPTH-1:0] cells;

    function automatic logic [AW-1:0] bit_idx(input logic [AW-1:0] base, input int off);
        logic [AW:0] s;
        s = {1'b0, base} + (AW+1)'(off);
        if (s >= (AW+1)'(DEPTH))
            s = s - (AW+1)'(DEPTH);
        return s[AW-1:0];
    endfunction

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < DW; i++) begin
                if (5'(i) < wwidth)
                    cells[bit_idx(waddr, i)] <= wdata[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            for (int i = 0; i < DW; i++)
                rdata[i] <= (5'(i) < rwidth) ? cells[bit_idx(raddr, i)] : 1'b0;
        end
    end
endmodule

// File: rtl/fifo_mw_flags.sv
// Bit-granular occupancy counter and registered status flags.
module fifo_mw_flags #(
    parameter int DEPTH = fifo_mw_pkg::ARRAY_BITS,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_acc,
    input  logic                           rd_acc,
    input  logic [fifo_mw_pkg::WID_W-1:0]  wr_w,
    input  logic [fifo_mw_pkg::WID_W-1:0]  rd_w,
    input  logic [CW-1:0]                  afull_lvl,
    input  logic [CW-1:0]                  aempty_lvl,
    output fifo_mw_pkg::fifo_flags_t       flags
);
    import fifo_mw_pkg::*;

    localparam int PW = CW + WID_W;

    logic [CW-1:0] occ, occ_next, room_next;
    logic [PW-1:0] af_bits, ae_bits;
    fifo_flags_t   flags_next;

    always_comb begin
        occ_next = occ;
        if (wr_acc) occ_next = occ_next + CW'(wr_w);
        if (rd_acc) occ_next = occ_next - CW'(rd_w);
        room_next = CW'(DEPTH) - occ_next;
        af_bits   = PW'(afull_lvl) * PW'(rd_w);
        ae_bits   = PW'(aempty_lvl) * PW'(rd_w);
        flags_next.empty  = occ_next < CW'(rd_w);
        flags_next.full   = room_next < CW'(wr_w);
        flags_next.afull  = PW'(occ_next) >= af_bits;
        flags_next.aempty = PW'(occ_next) <= ae_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ   <= '0;
            flags <= '{empty: 1'b1, full: 1'b0, aempty: 1'b1, afull: 1'b0};
        end else begin
            occ   <= occ_next;
            flags <= flags_next;
        end
    end
endmodule

// File: rtl/fifo_mw.sv
module fifo_mw #(
    parameter int DEPTH_BITS = fifo_mw_pkg::ARRAY_BITS,
    parameter int DATA_W     = fifo_mw_pkg::PORT_W,
    localparam int AW        = $clog2(DEPTH_BITS),
    localparam int CW        = $clog2(DEPTH_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        wr_mode,
    input  logic [2:0]        rd_mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CW-1:0]     afull_lvl,
    input  logic [CW-1:0]     aempty_lvl,
    output logic              empty,
    output logic              full,
    output logic              almost_empty,
    output logic              almost_full
);
    import fifo_mw_pkg::*;

    logic [WID_W-1:0] wr_w, rd_w;
    logic             wr_acc, rd_acc;
    logic [AW-1:0]    wptr, rptr;
    fifo_flags_t      flags;

    assign wr_w   = mode_width(wr_mode);
    assign rd_w   = mode_width(rd_mode);
    assign wr_acc = wr_en && !flags.full;
    assign rd_acc = rd_en && !flags.empty;

    fifo_mw_ptr #(.DEPTH(DEPTH_BITS), .AW(AW)) u_wptr (
        .clk(clk), .rst(rst), .adv(wr_acc), .step(wr_w), .ptr(wptr)
    );

    fifo_mw_ptr #(.DEPTH(DEPTH_BITS), .AW(AW)) u_rptr (
        .clk(clk), .rst(rst), .adv(rd_acc), .step(rd_w), .ptr(rptr)
    );

    fifo_mw_store #(.DEPTH(DEPTH_BITS), .DW(DATA_W), .AW(AW)) u_store (
        .clk(clk), .rst(rst),
        .we(wr_acc), .waddr(wptr), .wwidth(wr_w), .wdata(wr_data),
        .re(rd_acc), .raddr(rptr), .rwidth(rd_w), .rdata(rd_data)
    );

    fifo_mw_flags #(.DEPTH(DEPTH_BITS), .CW(CW)) u_flags (
        .clk(clk), .rst(rst), .wr_acc(wr_acc), .rd_acc(rd_acc),
        .wr_w(wr_w), .rd_w(rd_w),
        .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .flags(flags)
    );

    assign empty        = flags.empty;
    assign full         = flags.full;
    assign almost_empty = flags.aempty;
    assign almost_full  = flags.afull;
endmodule

// File: rtl/fifo_mw_chk.sv
module fifo_mw_chk #(
    parameter int DATA_W = fifo_mw_pkg::PORT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              empty,
    input logic              full,
    input logic              almost_empty,
    input logic              almost_full
);
    logic rst_seen = 1'b0;

    always_ff @(posedge clk) rst_seen <= rst;

    // R10: the edge that samples reset leaves the reset flag values
    always @(negedge clk) begin
        if (rst_seen) begin
            assert_reset_flags_R10: assert (empty && almost_empty && !full && !almost_full && rd_data == '0)
                else $error("reset flag values wrong");
        end
    end

    assert_full_excl_empty_R11: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    assert_write_full_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        full && wr_en && !rd_en |=> full);

    assert_read_empty_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        empty && rd_en |=> $stable(rd_data));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind fifo_mw fifo_mw_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
);

// File: tb/fifo_mw_tb.sv
module fifo_mw_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  wr_mode = 3'd0, rd_mode = 3'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic [12:0] afull_lvl = 13'd0, aempty_lvl = 13'd0;
    logic        empty, full, almost_empty, almost_full;

    int n_cmp = 0;
    int n_mis = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fifo_mw u_dut (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .rd_mode(rd_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .empty(empty), .full(full), .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] wm, input logic [2:0] rm);
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        wr_mode = wm; rd_mode = rm;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [17:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop(output logic [17:0] d);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        do_reset(3'd4, 3'd4);
        chk("R10", "empty", 32'(empty), 32'd1);
        chk("R10", "almost_empty", 32'(almost_empty), 32'd1);
        chk("R10", "full", 32'(full), 32'd0);
        chk("R10", "almost_full", 32'(almost_full), 32'd0);
        chk("R10", "rd_data", 32'(rd_data), 32'd0);
    endtask

    // write 4 bits, read 1 bit
    task automatic t_narrow_read;
        logic [17:0] d;
        logic [7:0]  exp_bits = 8'h3A;
        do_reset(3'd2, 3'd0);
        push(18'h3FFFA);
        push(18'h00003);
        for (int i = 0; i < 8; i++) begin
            pop(d);
            chk("R2", "narrow slice", 32'(d), 32'(exp_bits[i]));
        end
        chk("R1", "upper write bits not stored", 32'(empty), 32'd1);
    endtask

    // write narrow, read wide
    task automatic t_wide_read;
        logic [17:0] d;
        do_reset(3'd0, 3'd2);
        push(18'd1); push(18'd0); push(18'd1);
        chk("R5", "empty with 3 of 4 bits", 32'(empty), 32'd1);
        push(18'd1);
        chk("R5", "empty with 4 bits", 32'(empty), 32'd0);
        pop(d);
        chk("R3", "1-to-4 assembly", 32'(d), 32'hD);
        do_reset(3'd3, 3'd4);
        push(18'h001A5); push(18'h000F3);
        pop(d);
        chk("R3", "9-to-18 assembly", 32'(d), 32'h1E7A5);
    endtask

    task automatic t_full;
        logic [17:0] d;
        bit          seq_ok = 1'b1;
        do_reset(3'd4, 3'd4);
        for (int i = 0; i < 255; i++) push(18'(i + 7));
        chk("R11", "not full at 255 words", 32'(full), 32'd0);
        push(18'(255 + 7));
        chk("R11", "full at 256 words", 32'(full), 32'd1);
        push(18'h3FFFF);
        chk("R4", "still full after rejected write", 32'(full), 32'd1);
        for (int i = 0; i < 256; i++) begin
            pop(d);
            if (d !== 18'(i + 7)) begin
                seq_ok = 1'b0;
                chk("R4", "drain order", 32'(d), 32'(i + 7));
            end
        end
        chk("R4", "drain sequence intact", 32'(seq_ok), 32'd1);
        chk("R11", "empty after 256 reads", 32'(empty), 32'd1);
    endtask

    task automatic t_empty_read;
        logic [17:0] d;
        pop(d);
        chk("R5", "read while empty holds data", 32'(d), 32'(255 + 7));
        chk("R5", "still empty", 32'(empty), 32'd1);
    endtask

    task automatic t_latency;
        logic [17:0] d;
        do_reset(3'd3, 3'd3);
        push(18'h0155);
        rd_en = 1'b1;
        #1;
        chk("R6", "no data before edge", 32'(rd_data), 32'd0);
        @(negedge clk);
        rd_en = 1'b0;
        chk("R6", "data one cycle later", 32'(rd_data), 32'h155);
        repeat (3) @(negedge clk);
        d = rd_data;
        chk("R6", "data holds while idle", 32'(d), 32'h155);
    endtask

    task automatic t_simul;
        logic [17:0] d;
        do_reset(3'd3, 3'd3);
        push(18'h101); push(18'h0AA);
        wr_en = 1'b1; wr_data = 18'h155; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R7", "read side of simultaneous op", 32'(rd_data), 32'h101);
        pop(d);
        chk("R7", "second word", 32'(d), 32'h0AA);
        pop(d);
        chk("R7", "word written in simultaneous op", 32'(d), 32'h155);
        chk("R7", "empty afterwards", 32'(empty), 32'd1);
    endtask

    task automatic t_almost;
        logic [17:0] d;
        afull_lvl = 13'd3; aempty_lvl = 13'd1;
        do_reset(3'd2, 3'd2);
        push(18'h1);
        chk("R9", "ae at 1 word", 32'(almost_empty), 32'd1);
        push(18'h2);
        chk("R9", "ae clear at 2 words", 32'(almost_empty), 32'd0);
        chk("R8", "af clear at 2 words", 32'(almost_full), 32'd0);
        push(18'h3);
        chk("R8", "af at 3 words", 32'(almost_full), 32'd1);
        pop(d);
        chk("R8", "af clear after read", 32'(almost_full), 32'd0);
        afull_lvl = 13'd2;
        @(negedge clk);
        chk("R8", "af after runtime threshold change", 32'(almost_full), 32'd1);
        do_reset(3'd0, 3'd2);
        for (int i = 0; i < 4; i++) push(18'd1);
        chk("R9", "ae at 4 bits with 4-bit reads", 32'(almost_empty), 32'd1);
        push(18'd1);
        chk("R9", "ae clear at 5 bits", 32'(almost_empty), 32'd0);
        afull_lvl = 13'd0; aempty_lvl = 13'd0;
    endtask

    initial begin
        t_reset;
        t_narrow_read;
        t_wide_read;
        t_full;
        t_empty_read;
        t_latency;
        t_simul;
        t_almost;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end
endmodule